// File: doc/BRIEF.md
# Block-Transfer DMA Controller

This controller copies a contiguous run of 32-bit words between the local memory and a memory space reached over an external bus. Software loads a source pointer and a destination pointer through a small register write port. It then writes a control word that holds the byte count, the direction and the attribute for external writes. That control write launches the copy.

The engine moves one word at a time. It reads the word from the source port, then writes it to the destination port, so only one access is ever outstanding. It keeps private working pointers and a private remaining-count. The programmed registers are therefore never a record of progress. Completion sets a sticky done flag, and software clears it by writing a one. A bad request finishes at once with an error flag and no bus activity. The interrupt line is the done flag gated by an enable bit.

Each access port uses a plain request/acknowledge handshake. The engine holds the request, address and write data steady until it sees a one-cycle acknowledge. For a read, the data is returned in the same cycle as that acknowledge.

Top module: `dma_blk_ctl`

## Requirements
- R1: After reset, busy, done, err and irq are 0 and neither port requests.
- R2: A write to register select 2 (control) while idle starts a transfer. Busy is 1 in the cycle after that write. Control bits [25:0] are the byte count. Bit 26 is the direction. Bit 27 is the external write attribute.
- R3: Direction 0 copies local memory to external memory, and direction 1 copies external memory to local memory. Every word arrives at the destination unchanged.
- R4: The source and destination pointers advance by 4 per word. Exactly count/4 words are moved, and the word just past the end of the destination is left untouched. A request holds its address until it is acknowledged.
- R5: During a local-to-external transfer, every external write carries ext_inv equal to control bit 27.
- R6: A start is rejected if the source or destination has a nonzero value in bits [1:0], if the count is not a multiple of 4, or if the count is zero. A rejected start sets done and err in the next cycle, leaves busy at 0 and issues no request on either port.
- R7: When the last word's write is acknowledged, busy falls and done rises on the same edge. A write to register select 3 with bit 0 set clears done. Bit 1 clears err.
- R8: A control write received while busy is ignored, and the running transfer finishes with its original parameters.
- R9: irq equals done AND the interrupt enable. Every write to register select 3 loads the enable from bit 8.
- R10: A word is read from the source before it is written to the destination. The two ports never request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 source, 1 destination, 2 control, 3 status/enable |
| cfg_wdata | input | 32 | Register write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Sticky completion flag |
| err | output | 1 | Sticky rejected-start flag |
| irq | output | 1 | Interrupt request |
| loc_req | output | 1 | Local port request |
| loc_we | output | 1 | Local port write (1) or read (0) |
| loc_addr | output | 32 | Local port byte address |
| loc_wdata | output | 32 | Local port write data |
| loc_ack | input | 1 | Local port acknowledge |
| loc_rdata | input | 32 | Local port read data, valid with loc_ack |
| ext_req | output | 1 | External port request |
| ext_we | output | 1 | External port write (1) or read (0) |
| ext_inv | output | 1 | External write attribute (write-and-invalidate when 1) |
| ext_addr | output | 32 | External port byte address |
| ext_wdata | output | 32 | External port write data |
| ext_ack | input | 1 | External port acknowledge |
| ext_rdata | input | 32 | External port read data, valid with ext_ack |

## Verification
The hardest case to reach from the ports is a control write that lands in the middle of a running copy. The engine must visibly ignore it: the copy keeps its original direction, count and pointers.

The bench reaches this case by starting a sixteen-word local-to-external copy. Two cycles later it writes a conflicting control word that asks for a one-word copy in the other direction. It then counts the external writes and compares the destination contents against the first request alone.

The rejection paths are covered by vectors with a misaligned source, a misaligned destination, an odd count and a zero count. For each one, the bench checks that no request of any kind reached either memory model.

// File: rtl/dma_blk_pkg.sv
package dma_blk_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2
   } dma_st_e;

   localparam logic [1:0] SEL_SRC = 2'd0;
   localparam logic [1:0] SEL_DST = 2'd1;
   localparam logic [1:0] SEL_CTL = 2'd2;
   localparam logic [1:0] SEL_STS = 2'd3;

   localparam int STS_CLR_DONE = 0;
   localparam int STS_CLR_ERR  = 1;
   localparam int STS_IRQ_EN   = 8;
endpackage

// File: rtl/dma_blk_regs.sv
module dma_blk_regs
   import dma_blk_pkg::*;
#(
   parameter int AW   = 32,
   parameter int LENW = 26
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [1:0]      cfg_sel,
   input  logic [31:0]     cfg_wdata,
   input  logic            busy,
   output logic            start,
   output logic [LENW-1:0] start_len,
   output logic            start_dir,
   output logic            start_wtype,
   output logic            clr_done,
   output logic            clr_err,
   output logic            irq_en,
   output logic [AW-1:0]   src_q,
   output logic [AW-1:0]   dst_q
);
   localparam int DIR_BIT  = LENW;
   localparam int TYPE_BIT = LENW + 1;

   logic sts_wr;
   logic unused_hi;

   assign sts_wr      = cfg_we && (cfg_sel == SEL_STS);
   assign start       = cfg_we && (cfg_sel == SEL_CTL) && !busy;
   assign start_len   = cfg_wdata[LENW-1:0];
   assign start_dir   = cfg_wdata[DIR_BIT];
   assign start_wtype = cfg_wdata[TYPE_BIT];
   assign clr_done    = sts_wr && cfg_wdata[STS_CLR_DONE];
   assign clr_err     = sts_wr && cfg_wdata[STS_CLR_ERR];
   assign unused_hi   = ^{cfg_wdata[31:TYPE_BIT+1], cfg_wdata[STS_IRQ_EN-1:STS_CLR_ERR+1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         dst_q  <= '0;
         irq_en <= 1'b0;
      end else if (cfg_we) begin
         case (cfg_sel)
            SEL_SRC: src_q  <= cfg_wdata[AW-1:0];
            SEL_DST: dst_q  <= cfg_wdata[AW-1:0];
            SEL_STS: irq_en <= cfg_wdata[STS_IRQ_EN];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/dma_blk_engine.sv
module dma_blk_engine
   import dma_blk_pkg::*;
#(
   parameter int AW     = 32,
   parameter int DW     = 32,
   parameter int LENW   = 26,
   parameter bit STRICT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [LENW-1:0] start_len,
   input  logic            start_dir,
   input  logic            start_wtype,
   input  logic [AW-1:0]   src_q,
   input  logic [AW-1:0]   dst_q,
   input  logic            clr_done,
   input  logic            clr_err,
   output logic            busy,
   output logic            done,
   output logic            err,
   output logic            dir_q,
   output logic            wtype_q,
   output logic            rd_req,
   output logic [AW-1:0]   rd_addr,
   input  logic            rd_ack,
   input  logic [DW-1:0]   rd_data,
   output logic            wr_req,
   output logic [AW-1:0]   wr_addr,
   output logic [DW-1:0]   wr_data,
   input  logic            wr_ack
);
   localparam int BYTES = DW / 8;
   localparam int ALIGN = $clog2(BYTES);
   localparam logic [LENW-1:0] STEP_L = LENW'(BYTES);
   localparam logic [AW-1:0]   STEP_A = AW'(BYTES);

   dma_st_e         st;
   logic [AW-1:0]   src_p, dst_p;
   logic [LENW-1:0] rem;
   logic [DW-1:0]   hold;
   logic            req_ok;
   logic            len_ok;

   assign len_ok = (start_len != '0) && (start_len[ALIGN-1:0] == '0);

   generate
      if (STRICT) begin : g_strict
         assign req_ok = len_ok && (src_q[ALIGN-1:0] == '0) && (dst_q[ALIGN-1:0] == '0);
      end else begin : g_lenient
         assign req_ok = len_ok;
      end
   endgenerate

   assign busy    = (st != ST_IDLE);
   assign rd_req  = (st == ST_RD);
   assign wr_req  = (st == ST_WR);
   assign rd_addr = {src_p[AW-1:ALIGN], {ALIGN{1'b0}}};
   assign wr_addr = {dst_p[AW-1:ALIGN], {ALIGN{1'b0}}};
   assign wr_data = hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         src_p   <= '0;
         dst_p   <= '0;
         rem     <= '0;
         hold    <= '0;
         done    <= 1'b0;
         err     <= 1'b0;
         dir_q   <= 1'b0;
         wtype_q <= 1'b0;
      end else begin
         if (clr_done) done <= 1'b0;
         if (clr_err)  err  <= 1'b0;
         case (st)
            ST_IDLE: if (start) begin
               if (!req_ok) begin
                  done <= 1'b1;
                  err  <= 1'b1;
               end else begin
                  st      <= ST_RD;
                  src_p   <= src_q;
                  dst_p   <= dst_q;
                  rem     <= start_len;
                  dir_q   <= start_dir;
                  wtype_q <= start_wtype;
               end
            end
            ST_RD: if (rd_ack) begin
               hold <= rd_data;
               st   <= ST_WR;
            end
            ST_WR: if (wr_ack) begin
               src_p <= src_p + STEP_A;
               dst_p <= dst_p + STEP_A;
               rem   <= rem - STEP_L;
               if (rem == STEP_L) begin
                  st   <= ST_IDLE;
                  done <= 1'b1;
               end else begin
                  st <= ST_RD;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dma_blk_route.sv
module dma_blk_route #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input  logic          dir_q,
   input  logic          wtype_q,
   input  logic          rd_req,
   input  logic [AW-1:0] rd_addr,
   output logic          rd_ack,
   output logic [DW-1:0] rd_data,
   input  logic          wr_req,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   output logic          wr_ack,
   output logic          loc_req,
   output logic          loc_we,
   output logic [AW-1:0] loc_addr,
   output logic [DW-1:0] loc_wdata,
   input  logic          loc_ack,
   input  logic [DW-1:0] loc_rdata,
   output logic          ext_req,
   output logic          ext_we,
   output logic          ext_inv,
   output logic [AW-1:0] ext_addr,
   output logic [DW-1:0] ext_wdata,
   input  logic          ext_ack,
   input  logic [DW-1:0] ext_rdata
);
   assign loc_req   = dir_q ? wr_req  : rd_req;
   assign loc_we    = dir_q;
   assign loc_addr  = dir_q ? wr_addr : rd_addr;
   assign loc_wdata = wr_data;
   assign ext_req   = dir_q ? rd_req  : wr_req;
   assign ext_we    = !dir_q;
   assign ext_inv   = wtype_q && !dir_q;
   assign ext_addr  = dir_q ? rd_addr : wr_addr;
   assign ext_wdata = wr_data;
   assign rd_ack    = dir_q ? ext_ack   : loc_ack;
   assign rd_data   = dir_q ? ext_rdata : loc_rdata;
   assign wr_ack    = dir_q ? loc_ack   : ext_ack;
endmodule

// File: rtl/dma_blk_ctl.sv
module dma_blk_ctl #(
   parameter int AW     = 32,
   parameter int DW     = 32,
   parameter int LENW   = 26,
   parameter bit STRICT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [1:0]    cfg_sel,
   input  logic [31:0]   cfg_wdata,
   output logic          busy,
   output logic          done,
   output logic          err,
   output logic          irq,
   output logic          loc_req,
   output logic          loc_we,
   output logic [AW-1:0] loc_addr,
   output logic [DW-1:0] loc_wdata,
   input  logic          loc_ack,
   input  logic [DW-1:0] loc_rdata,
   output logic          ext_req,
   output logic          ext_we,
   output logic          ext_inv,
   output logic [AW-1:0] ext_addr,
   output logic [DW-1:0] ext_wdata,
   input  logic          ext_ack,
   input  logic [DW-1:0] ext_rdata
);
   generate
      if (LENW + 2 > 32) begin : g_bad_lenw
         $error("LENW leaves no room for direction and type bits");
      end
      if (DW % 8 != 0 || DW < 16) begin : g_bad_dw
         $error("DW must be a whole number of bytes, at least two");
      end
      if (AW > 32 || AW <= $clog2(DW / 8)) begin : g_bad_aw
         $error("AW out of range");
      end
   endgenerate

   logic            start, start_dir, start_wtype, clr_done, clr_err, irq_en;
   logic [LENW-1:0] start_len;
   logic [AW-1:0]   src_q, dst_q, rd_addr, wr_addr;
   logic [DW-1:0]   rd_data, wr_data;
   logic            dir_q, wtype_q, rd_req, rd_ack, wr_req, wr_ack;

   dma_blk_regs #(.AW(AW), .LENW(LENW)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .busy(busy), .start(start),
      .start_len(start_len), .start_dir(start_dir), .start_wtype(start_wtype),
      .clr_done(clr_done), .clr_err(clr_err), .irq_en(irq_en),
      .src_q(src_q), .dst_q(dst_q)
   );

   dma_blk_engine #(.AW(AW), .DW(DW), .LENW(LENW), .STRICT(STRICT)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(start), .start_len(start_len),
      .start_dir(start_dir), .start_wtype(start_wtype), .src_q(src_q),
      .dst_q(dst_q), .clr_done(clr_done), .clr_err(clr_err), .busy(busy),
      .done(done), .err(err), .dir_q(dir_q), .wtype_q(wtype_q),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
      .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack)
   );

   dma_blk_route #(.AW(AW), .DW(DW)) u_route (
      .dir_q(dir_q), .wtype_q(wtype_q), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_ack(rd_ack), .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr),
      .wr_data(wr_data), .wr_ack(wr_ack), .loc_req(loc_req), .loc_we(loc_we),
      .loc_addr(loc_addr), .loc_wdata(loc_wdata), .loc_ack(loc_ack),
      .loc_rdata(loc_rdata), .ext_req(ext_req), .ext_we(ext_we),
      .ext_inv(ext_inv), .ext_addr(ext_addr), .ext_wdata(ext_wdata),
      .ext_ack(ext_ack), .ext_rdata(ext_rdata)
   );

   assign irq = done && irq_en;
endmodule

// File: rtl/dma_blk_chk.sv
module dma_blk_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          err,
   input logic          irq,
   input logic          loc_req,
   input logic          loc_ack,
   input logic [AW-1:0] loc_addr,
   input logic          ext_req,
   input logic          ext_ack,
   input logic [AW-1:0] ext_addr,
   input logic          ext_inv
);
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!loc_req && !ext_req));

   a_r10_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
      !(loc_req && ext_req));

   a_r4_loc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_req && !loc_ack) |=> (loc_req && $stable(loc_addr)));

   a_r4_ext_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr)));

   a_r7_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   a_r6_err_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> !busy);

   a_r5_attr_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(ext_inv));

   a_r9_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> done);
endmodule

bind dma_blk_ctl dma_blk_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err), .irq(irq),
   .loc_req(loc_req), .loc_ack(loc_ack), .loc_addr(loc_addr),
   .ext_req(ext_req), .ext_ack(ext_ack), .ext_addr(ext_addr), .ext_inv(ext_inv)
);

// File: tb/dma_blk_ctl_tb.sv
module dma_blk_ctl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 8;

   typedef struct packed {
      logic [31:0] src;
      logic [31:0] dst;
      logic [31:0] ctl;
      logic        bad;
   } vec_t;

   // ctl: [25:0] bytes, [26] direction, [27] write attribute
   localparam vec_t VECS [NV] = '{
      '{32'h0000_0000, 32'h0000_0010, 32'h0000_0010, 1'b0},
      '{32'h0000_0020, 32'h0000_0040, 32'h0400_0004, 1'b0},
      '{32'h0000_0004, 32'h0000_0080, 32'h0800_0020, 1'b0},
      '{32'h0000_0002, 32'h0000_0040, 32'h0000_0008, 1'b1},
      '{32'h0000_0000, 32'h0000_0040, 32'h0000_0006, 1'b1},
      '{32'h0000_0000, 32'h0000_0040, 32'h0000_0000, 1'b1},
      '{32'h0000_0010, 32'h0000_0041, 32'h0400_0008, 1'b1},
      '{32'h0000_0100, 32'h0000_0000, 32'h0400_0028, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        busy, done, err, irq;
   logic        loc_req, loc_we, loc_ack = 1'b0;
   logic [31:0] loc_addr, loc_wdata, loc_rdata = '0;
   logic        ext_req, ext_we, ext_inv, ext_ack = 1'b0;
   logic [31:0] ext_addr, ext_wdata, ext_rdata = '0;

   logic [31:0] lmem [64];
   logic [31:0] emem [64];
   int          checks = 0, errors = 0, cycles = 0;
   int          loc_cnt = 0, ext_cnt = 0, ext_wr_cnt = 0, inv_bad = 0, overlap = 0;
   logic        exp_inv = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dma_blk_ctl u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .busy(busy), .done(done), .err(err), .irq(irq),
      .loc_req(loc_req), .loc_we(loc_we), .loc_addr(loc_addr),
      .loc_wdata(loc_wdata), .loc_ack(loc_ack), .loc_rdata(loc_rdata),
      .ext_req(ext_req), .ext_we(ext_we), .ext_inv(ext_inv),
      .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_ack(ext_ack),
      .ext_rdata(ext_rdata)
   );

   function automatic logic [31:0] lpat(int i); return 32'hA500_0000 | 32'(i); endfunction
   function automatic logic [31:0] epat(int i); return 32'h5A00_0000 | 32'(i); endfunction

   // memory models: one-cycle acknowledge
   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (loc_req && ext_req) overlap <= overlap + 1;
      loc_ack <= loc_req && !loc_ack;
      if (loc_req && !loc_ack) begin
         loc_cnt <= loc_cnt + 1;
         if (loc_we) lmem[loc_addr[7:2]] <= loc_wdata;
         else        loc_rdata <= lmem[loc_addr[7:2]];
      end
      ext_ack <= ext_req && !ext_ack;
      if (ext_req && !ext_ack) begin
         ext_cnt <= ext_cnt + 1;
         if (ext_we) begin
            emem[ext_addr[7:2]] <= ext_wdata;
            ext_wr_cnt <= ext_wr_cnt + 1;
            if (ext_inv !== exp_inv) inv_bad <= inv_bad + 1;
         end else begin
            ext_rdata <= emem[ext_addr[7:2]];
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic prep();
      @(negedge clk);
      for (int i = 0; i < 64; i++) begin
         lmem[i] = lpat(i);
         emem[i] = epat(i);
      end
      loc_cnt = 0; ext_cnt = 0; ext_wr_cnt = 0; inv_bad = 0; overlap = 0;
   endtask

   task automatic wait_done(input string req);
      int n = 0;
      while (!done && n < 2000) begin
         @(negedge clk);
         n++;
      end
      chk(done == 1'b1, req, 32'(done), 32'd1);
   endtask

   task automatic check_copy(input logic [31:0] src, input logic [31:0] dst, input logic [31:0] ctl);
      int nw = int'(ctl[25:0]) / 4;
      int bad = 0;
      int di;
      for (int k = 0; k < nw; k++) begin
         int si = ((int'(src) >> 2) + k) & 63;
         int dk = ((int'(dst) >> 2) + k) & 63;
         logic [31:0] e = ctl[26] ? epat(si) : lpat(si);
         logic [31:0] a = ctl[26] ? lmem[dk] : emem[dk];
         if (a !== e) bad++;
      end
      chk(bad == 0, "R3 words copied", 32'(bad), 32'd0);
      di = ((int'(dst) >> 2) + nw) & 63;
      if (ctl[26]) chk(lmem[di] === lpat(di), "R4 word past end", lmem[di], lpat(di));
      else         chk(emem[di] === epat(di), "R4 word past end", emem[di], epat(di));
      chk((loc_cnt == nw) && (ext_cnt == nw), "R4 word count per port",
          32'(loc_cnt + ext_cnt), 32'(2 * nw));
      if (!ctl[26]) chk(inv_bad == 0 && ext_wr_cnt == nw, "R5 write attribute", 32'(inv_bad), 32'd0);
      chk(overlap == 0, "R10 single request", 32'(overlap), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({busy, done, err, irq, loc_req, ext_req} == 6'b0, "R1 reset outputs",
          32'({busy, done, err, irq, loc_req, ext_req}), 32'd0);
      rst_n = 1'b1;

      for (int v = 0; v < NV; v++) begin
         prep();
         exp_inv = VECS[v].ctl[27];
         wr_reg(2'd0, VECS[v].src);
         wr_reg(2'd1, VECS[v].dst);
         wr_reg(2'd2, VECS[v].ctl);
         if (VECS[v].bad) begin
            chk(done && err && !busy, "R6 rejected start flags",
                32'({done, err, busy}), 32'b110);
            repeat (4) @(negedge clk);
            chk(loc_cnt == 0 && ext_cnt == 0, "R6 no requests",
                32'(loc_cnt + ext_cnt), 32'd0);
         end else begin
            chk(busy == 1'b1, "R2 busy after start", 32'(busy), 32'd1);
            wait_done("R7 done set");
            chk(!busy && !err, "R7 busy clear at done", 32'({busy, err}), 32'd0);
            check_copy(VECS[v].src, VECS[v].dst, VECS[v].ctl);
         end
         wr_reg(2'd3, 32'h0000_0003);
         chk(!done && !err, "R7 write-one clears", 32'({done, err}), 32'd0);
      end

      // R9: interrupt gating
      prep();
      exp_inv = 1'b0;
      wr_reg(2'd0, 32'h0); wr_reg(2'd1, 32'h0); wr_reg(2'd2, 32'h0000_0008);
      wait_done("R9 transfer done");
      @(negedge clk);
      chk(irq == 1'b0, "R9 irq masked", 32'(irq), 32'd0);
      wr_reg(2'd3, 32'h0000_0100);
      chk(irq == 1'b1 && done, "R9 irq enabled", 32'(irq), 32'd1);
      wr_reg(2'd3, 32'h0000_0101);
      chk(irq == 1'b0, "R9 irq drops with done", 32'(irq), 32'd0);
      wr_reg(2'd3, 32'h0000_0000);

      // R8: control write while busy is ignored
      prep();
      exp_inv = 1'b0;
      wr_reg(2'd0, 32'h0000_0000); wr_reg(2'd1, 32'h0000_0040);
      wr_reg(2'd2, 32'h0000_0040);
      wr_reg(2'd2, 32'h0C00_0004);
      chk(busy == 1'b1, "R8 still busy", 32'(busy), 32'd1);
      wait_done("R8 done");
      chk(ext_wr_cnt == 16 && inv_bad == 0, "R8 original copy kept",
          32'(ext_wr_cnt), 32'd16);
      check_copy(32'h0, 32'h40, 32'h0000_0040);
      wr_reg(2'd3, 32'h0000_0003);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      wait (cycles > 50000);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, actual=%0d expected<50000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule